// File: doc/BRIEF.md
# Strided Vector Move/Swap Engine

This engine copies one strided vector of multi-word elements into another, or exchanges the contents of the two vectors. It sits on the memory side of a datapath and reaches a single-port, word-addressed memory through a request/ready handshake, one word per access. Elements are opaque: the engine never looks inside a word, it only moves it.

A command is one `start_i` pulse. The pulse carries two base addresses, two signed strides counted in elements, a signed element count, a precision select and a move/swap select. A single-precision element occupies two words and a double-precision element occupies four. Each stride is scaled by that element size to give the address step. For every element the engine first reads the source element and then the destination element. It then writes the source values to the destination. In swap mode it finally writes the destination's earlier values back to the source. `done_o` pulses once when the command has finished.

Top module: `vec_xfer_engine`

## Requirements
- R1: An element is 2 words when `dbl_i`=0 and 4 words when `dbl_i`=1. Each word takes one memory access, and the words of an element go in increasing address order starting at the element address.
- R2: A stride is a signed 16-bit element count. The address step is the stride times the element word count, so a negative stride walks downward.
- R3: A count of zero or less makes no memory access at all. `done_o` then pulses in the cycle right after the start cycle.
- R4: For each element the order is: read all words at the A address, then read all words at the B address, then write the A values to the B address. With `swap_i`=0 no write goes to the A vector.
- R5: With `swap_i`=1, after the B writes the engine writes the B values that it read before any write to the A address.
- R6: After each element both addresses advance by their own scaled step. Addresses are 15 bits wide and wrap modulo 2^15, including inside an element.
- R7: After reset `busy_o`, `done_o` and `mem_req_o` are 0. `done_o` is high for exactly one cycle, the cycle after the last accepted access, and `busy_o` is low in that cycle.
- R8: A `start_i` pulse that arrives while `busy_o` is high is ignored. The running command continues unchanged and no second command follows it.
- R9: An access completes on a clock edge where `mem_req_o` and `mem_ready_i` are both high. While `mem_ready_i` is low, the address, write enable and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command pulse, sampled while idle |
| base_a_i | input | 15 | Start address of vector A (source) |
| base_b_i | input | 15 | Start address of vector B (destination) |
| stride_a_i | input | 16 | Signed element stride of A |
| stride_b_i | input | 16 | Signed element stride of B |
| count_i | input | 16 | Signed element count |
| dbl_i | input | 1 | 1: four-word elements, 0: two-word elements |
| swap_i | input | 1 | 1: exchange the vectors, 0: copy A to B |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1: write access, 0: read access |
| mem_addr_o | output | 15 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Access accepted on this edge |
| mem_rdata_i | input | 16 | Read data, valid while ready is high on a read |

## Verification
The assertions assume that `mem_ready_i` is only meaningful while a request is pending. They also assume that the read data is valid in the same cycle as ready, so a slow memory simply holds ready low. The memory model follows this contract: it raises ready only as a stall pattern and returns data combinationally in the accepting cycle. It never depends on ready while no request is pending. Start pulses are driven one cycle wide on the falling edge. Each command is given time to finish before the next, except for the deliberate restart pulse that tests R8.

// File: rtl/vxe_pkg.sv
package vxe_pkg;
  localparam int unsigned ADDR_W    = 15;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ARG_W     = 16;
  localparam int unsigned SGL_WORDS = 2;
  localparam int unsigned DBL_WORDS = 4;
  localparam int unsigned IDX_W     = $clog2(DBL_WORDS);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_A,
    PH_RD_B,
    PH_WR_B,
    PH_WR_A
  } phase_e;
endpackage

// File: rtl/vxe_addr_gen.sv
module vxe_addr_gen import vxe_pkg::*; #(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned SW    = ARG_W,
  parameter int unsigned LANES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     step_i,
  input  logic                     dbl_i,
  input  logic [LANES-1:0][AW-1:0] base_i,
  input  logic [LANES-1:0][SW-1:0] stride_i,
  output logic [LANES-1:0][AW-1:0] ptr_o
);
  localparam int unsigned SGL_SH = $clog2(SGL_WORDS);
  localparam int unsigned DBL_SH = $clog2(DBL_WORDS);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW-1:0] ptr_q, inc_q, scaled;

    // scale once at load so the per-element step is a plain add
    always_comb scaled = AW'(stride_i[g]) << (dbl_i ? DBL_SH : SGL_SH);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q <= '0;
        inc_q <= '0;
      end else if (load_i) begin
        ptr_q <= base_i[g];
        inc_q <= scaled;
      end else if (step_i) begin
        ptr_q <= ptr_q + inc_q;
      end
    end

    assign ptr_o[g] = ptr_q;
  end
endmodule

// File: rtl/vxe_elem_buf.sv
module vxe_elem_buf import vxe_pkg::*; #(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned WORDS = DBL_WORDS,
  parameter int unsigned IW    = IDX_W
) (
  input  logic          clk_i,
  input  logic          cap_a_i,
  input  logic          cap_b_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] word_a_o,
  output logic [DW-1:0] word_b_o
);
  logic [DW-1:0] buf_a [WORDS];
  logic [DW-1:0] buf_b [WORDS];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < WORDS; i++) begin
      if (cap_a_i && idx_i == IW'(i)) buf_a[i] <= data_i;
      if (cap_b_i && idx_i == IW'(i)) buf_b[i] <= data_i;
    end
  end

  assign word_a_o = buf_a[idx_i];
  assign word_b_o = buf_b[idx_i];
endmodule

// File: rtl/vxe_ctrl.sv
module vxe_ctrl import vxe_pkg::*; #(
  parameter int unsigned CW = ARG_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          dbl_i,
  input  logic          swap_i,
  input  logic          ready_i,
  output phase_e        phase_o,
  output logic [IW-1:0] widx_o,
  output logic          load_o,
  output logic          step_o,
  output logic          done_o
);
  phase_e        phase_q;
  logic [IW-1:0] widx_q, last_idx;
  logic [CW-1:0] remain_q;
  logic          swap_q, dbl_q, done_q;
  logic          word_last, phase_end, elem_end;

  always_comb begin
    last_idx  = dbl_q ? IW'(DBL_WORDS - 1) : IW'(SGL_WORDS - 1);
    word_last = (widx_q == last_idx);
    load_o    = (phase_q == PH_IDLE) && start_i;
    phase_end = (phase_q != PH_IDLE) && ready_i && word_last;
    elem_end  = phase_end && ((phase_q == PH_WR_A) || (phase_q == PH_WR_B && !swap_q));
    step_o    = elem_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      widx_q   <= '0;
      remain_q <= '0;
      swap_q   <= 1'b0;
      dbl_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          swap_q   <= swap_i;
          dbl_q    <= dbl_i;
          widx_q   <= '0;
          remain_q <= count_i;
          if ($signed(count_i) > 0) phase_q <= PH_RD_A;
          else                      done_q  <= 1'b1;
        end
      end else if (ready_i) begin
        if (!word_last) begin
          widx_q <= widx_q + 1'b1;
        end else begin
          widx_q <= '0;
          if (elem_end) begin
            if (remain_q == CW'(1)) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              remain_q <= remain_q - 1'b1;
              phase_q  <= PH_RD_A;
            end
          end else begin
            unique case (phase_q)
              PH_RD_A: phase_q <= PH_RD_B;
              PH_RD_B: phase_q <= PH_WR_B;
              default: phase_q <= PH_WR_A;
            endcase
          end
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign widx_o  = widx_q;
  assign done_o  = done_q;
endmodule

// File: rtl/vec_xfer_engine.sv
module vec_xfer_engine import vxe_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] base_b_i,
  input  logic [ARG_W-1:0]  stride_a_i,
  input  logic [ARG_W-1:0]  stride_b_i,
  input  logic [ARG_W-1:0]  count_i,
  input  logic              dbl_i,
  input  logic              swap_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  phase_e                 phase;
  logic [IDX_W-1:0]       widx;
  logic                   load, step, side_a;
  logic [1:0][ADDR_W-1:0] ptr;
  logic [DATA_W-1:0]      word_a, word_b;

  vxe_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .count_i (count_i),
    .dbl_i   (dbl_i),
    .swap_i  (swap_i),
    .ready_i (mem_ready_i),
    .phase_o (phase),
    .widx_o  (widx),
    .load_o  (load),
    .step_o  (step),
    .done_o  (done_o)
  );

  vxe_addr_gen u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .dbl_i    (dbl_i),
    .base_i   ({base_b_i, base_a_i}),
    .stride_i ({stride_b_i, stride_a_i}),
    .ptr_o    (ptr)
  );

  vxe_elem_buf u_buf (
    .clk_i    (clk_i),
    .cap_a_i  (phase == PH_RD_A && mem_ready_i),
    .cap_b_i  (phase == PH_RD_B && mem_ready_i),
    .idx_i    (widx),
    .data_i   (mem_rdata_i),
    .word_a_o (word_a),
    .word_b_o (word_b)
  );

  always_comb begin
    side_a      = (phase == PH_RD_A) || (phase == PH_WR_A);
    busy_o      = (phase != PH_IDLE);
    mem_req_o   = busy_o;
    mem_we_o    = (phase == PH_WR_B) || (phase == PH_WR_A);
    mem_addr_o  = (side_a ? ptr[0] : ptr[1]) + ADDR_W'(widx);
    mem_wdata_o = !mem_we_o ? '0 : ((phase == PH_WR_B) ? word_a : word_b);
  end
endmodule

// File: rtl/vxe_checker.sv
module vxe_checker import vxe_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ready_i
);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !mem_req_o));

  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r4_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !mem_we_o);

  a_r8_no_early_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_ready_i) |=> busy_o);
endmodule

bind vec_xfer_engine vxe_checker u_chk (.*);

// File: tb/sim_vec_xfer_engine.sv
`timescale 1ns/1ps
module sim_vec_xfer_engine;
  typedef struct packed {
    logic        we;
    logic [14:0] addr;
    logic [15:0] data;
  } acc_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, dbl = 1'b0, swp = 1'b0;
  logic [14:0] base_a = '0, base_b = '0;
  logic [15:0] stride_a = '0, stride_b = '0, count = '0;
  logic        busy, done, mem_req, mem_we, mem_ready = 1'b0;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;

  logic [15:0] mem     [int];
  logic [15:0] ref_mem [int];
  acc_t        exp_q   [$];
  int          n_run = 0, n_fail = 0;
  string       cur_req = "R7";
  bit          stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  vec_xfer_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .base_a_i(base_a), .base_b_i(base_b),
    .stride_a_i(stride_a), .stride_b_i(stride_b), .count_i(count),
    .dbl_i(dbl), .swap_i(swp), .busy_o(busy), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [15:0] init_val(input logic [14:0] a);
    return {1'b0, a} ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] dut_rd(input logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_val(a);
  endfunction

  function automatic logic [15:0] ref_rd(input logic [14:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // monitor: drives ready/rdata, applies writes, pops the scoreboard
  initial begin : monitor
    bit          prev_stall = 1'b0;
    logic [14:0] prev_addr  = '0;
    forever begin
      @(negedge clk);
      if (stall_en) begin
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = |lfsr[1:0];
      end else begin
        mem_ready = 1'b1;
      end
      #1;
      if (prev_stall && mem_req)
        chk(mem_addr == prev_addr, "R9", "address held during stall",
            32'(mem_addr), 32'(prev_addr));
      if (rst_n && mem_req && mem_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected access", {16'(mem_we), 1'b0, mem_addr}, 32'hFFFFFFFF);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
              cur_req, "access",
              {mem_we, mem_addr, mem_we ? mem_wdata : 16'h0},
              {e.we, e.addr, e.data});
        end
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        else        mem_rdata = dut_rd(mem_addr);
      end
      prev_stall = mem_req && !mem_ready;
      prev_addr  = mem_addr;
    end
  end

  // driver: builds the expected access stream from the requirements, then runs a command
  task automatic run(input string req, input logic [14:0] ba, input logic [14:0] bb,
                     input logic signed [15:0] sa, input logic signed [15:0] sb,
                     input logic signed [15:0] cnt, input logic d, input logic s,
                     input bit restart);
    int          w;
    int          cyc;
    logic [14:0] pa, pb, a;
    logic [15:0] va [4];
    logic [15:0] vb [4];
    w  = d ? 4 : 2;
    pa = ba;
    pb = bb;
    ref_mem = mem;
    exp_q.delete();
    for (int e = 0; e < int'(cnt); e++) begin
      for (int i = 0; i < w; i++) begin
        a = pa + 15'(i); va[i] = ref_rd(a);
        exp_q.push_back('{we: 1'b0, addr: a, data: 16'h0});
      end
      for (int i = 0; i < w; i++) begin
        a = pb + 15'(i); vb[i] = ref_rd(a);
        exp_q.push_back('{we: 1'b0, addr: a, data: 16'h0});
      end
      for (int i = 0; i < w; i++) begin
        a = pb + 15'(i); ref_mem[int'(a)] = va[i];
        exp_q.push_back('{we: 1'b1, addr: a, data: va[i]});
      end
      if (s)
        for (int i = 0; i < w; i++) begin
          a = pa + 15'(i); ref_mem[int'(a)] = vb[i];
          exp_q.push_back('{we: 1'b1, addr: a, data: vb[i]});
        end
      pa = pa + 15'(int'(sa) * w);
      pb = pb + 15'(int'(sb) * w);
    end
    cur_req = req;
    @(negedge clk);
    base_a = ba; base_b = bb; stride_a = sa; stride_b = sb;
    count = cnt; dbl = d; swp = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc   = 1;
    while (!done && cyc < 20000) begin
      if (restart && cyc == 3) begin
        // R8: a second command while busy must be ignored
        start = 1'b1; base_a = bb; base_b = ba; count = 16'd1; swp = ~s; dbl = ~d;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done, req, "done seen", 32'(done), 32'd1);
    chk(exp_q.size() == 0, req, "accesses left at done", 32'(exp_q.size()), 32'd0);
    if (int'(cnt) <= 0)
      chk(cyc == 1, "R3", "done delay for empty count", 32'(cyc), 32'd1);
    @(negedge clk);
    chk(!done && !busy, "R7", "done single pulse", {30'd0, done, busy}, 32'd0);
    repeat (3) @(negedge clk);
    chk(!busy, "R8", "no extra command after done", 32'(busy), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R7", "reset state",
        {29'd0, busy, done, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run("R1", 15'h0100, 15'h0200, 16'sd1, 16'sd1, 16'sd3, 1'b0, 1'b0, 1'b0);
    run("R4", 15'h0300, 15'h0400, 16'sd2, 16'sd1, 16'sd2, 1'b1, 1'b0, 1'b0);
    run("R2", 15'h0500, 15'h0600, 16'sd3, -16'sd1, 16'sd4, 1'b1, 1'b0, 1'b0);
    run("R5", 15'h0700, 15'h0710, 16'sd1, 16'sd2, 16'sd3, 1'b0, 1'b1, 1'b0);
    stall_en = 1'b1;
    run("R9", 15'h0800, 15'h0900, -16'sd2, 16'sd1, 16'sd3, 1'b1, 1'b1, 1'b0);
    run("R4", 15'h0A00, 15'h0A02, 16'sd1, 16'sd1, 16'sd4, 1'b0, 1'b0, 1'b0);
    stall_en = 1'b0;
    run("R3", 15'h0B00, 15'h0C00, 16'sd1, 16'sd1, 16'sd0, 1'b0, 1'b1, 1'b0);
    run("R3", 15'h0B00, 15'h0C00, 16'sd1, 16'sd1, -16'sd5, 1'b1, 1'b0, 1'b0);
    run("R6", 15'h7FFE, 15'h0010, 16'sd1, 16'sd0, 16'sd3, 1'b1, 1'b1, 1'b0);
    run("R6", 15'h0002, 15'h7FF0, -16'sd1, 16'sd2, 16'sd3, 1'b0, 1'b0, 1'b0);
    stall_en = 1'b1;
    run("R8", 15'h0D00, 15'h0E00, 16'sd1, 16'sd1, 16'sd4, 1'b0, 1'b0, 1'b1);
    run("R8", 15'h0F00, 15'h1000, 16'sd1, -16'sd3, 16'sd2, 1'b1, 1'b1, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule